// File: doc/BRIEF.md
# FIFO-Backed SPI Master with Register Access

This block is an SPI master that software drives through a small 32-bit register port. Software writes transmit words into an eight-entry TX FIFO, programs word length, clock mode, divider and target select in a control word, then sets a start bit. The shift engine pops each word, sends it most-significant bit first on `mosi` while toggling `sclk`, and captures `miso` into an eight-entry RX FIFO. Software reads received words back one at a time. Each read of the receive location removes one word.

Chip-select outputs are driven with a programmable active level. They stay active for a whole burst, or drop between words, as the control word selects. The serial clock is the system clock divided by four times a power of two. A single interrupt line merges a TX-empty condition and an RX-ready condition, each behind its own enable.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the control word (offset 0x08) and the interrupt-enable word (offset 0x0C) read 0, the status word (offset 0x14) reads 1, every chip select is high, `sclk`, `mosi` and `irq` are low. Control bits that are written read back unchanged (mask 0x0307_1FF7), and so do interrupt-enable bits 0 and 3.
- R2: A write to offset 0x04 queues a TX word. With control bit 0 (enable) and bit 1 (master) set, writing bit 2 (start) sends every queued word in order, MSB first. Each word is N bits long, and bits [12:8] of the control word hold N−1, so N runs from 1 to 32.
- R3: The `sclk` period is 4·2^k system clocks, where k sits in control bits [18:16] and runs from 0 to 7.
- R4: `sclk` idles at the level of control bit 4. With control bit 5 at 0, `mosi` changes only on trailing edges and is valid at every leading edge. With bit 5 at 1, `mosi` changes on leading edges and is valid at trailing edges. The bit captured from `miso` at that same valid edge lands in the received word, with the first bit captured as the MSB.
- R5: Each finished word enters the RX FIFO. A read of offset 0x00 returns the oldest word and removes it. A read of an empty RX FIFO returns 0. Status bit 3 is 1 while the RX FIFO holds a word.
- R6: The TX FIFO holds 8 words, and a write to 0x04 while it is full is discarded. Status bit 2 is 1 while it is full and status bit 0 is 1 while it is empty.
- R7: The start bit clears itself once the TX FIFO is empty and the last word has finished shifting. Setting it with an empty TX FIFO clears it with no chip-select activity.
- R8: Control bits [25:24] pick one of four chip selects, and control bit 7 gives the active level. The other lines and idle lines sit at the opposite level. With control bit 6 at 0 the select stays active across a whole burst. With bit 6 at 1 it drops for half an `sclk` period between words.
- R9: `irq` is high when interrupt-enable bit 0 is set and the TX FIFO is empty, or when enable bit 3 is set and the RX FIFO is not empty.
- R10: A word that finishes while the RX FIFO already holds 8 words is discarded, and the stored words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, valid in the access cycle |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |

## Verification
The bench targets these cases:
- **Mode coverage.** All four clock modes run with word lengths of 1, 4, 5, 8, 16 and 32 bits. An engine that sampled on the wrong edge, or shifted the first bit too early under phase 1, would deliver words that are rotated by one bit.
- **Divider extremes.** The slowest divider code is measured edge to edge. An off-by-one in the half-period counter shows up as a wrong period.
- **FIFO limits.** A ninth TX write and a ninth received word must both vanish. Wrapping pointers or overflowing counters would corrupt the order of the eight valid words or return a stale word where zero is due.
- **Chip-select behaviour.** Select activations are counted per burst under both select styles. A select that dropped between words in burst mode, or held in per-word mode, gives the wrong count.
- **Interrupt terms.** Each interrupt enable is checked against FIFO state separately.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DEPTH = 8,
  parameter int NCS   = 4,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic [NCS-1:0] cs_o
);
  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = PW + 1;
  localparam int CSW = $clog2(NCS);
  localparam logic [AW-1:0] A_RX = AW'(8'h00), A_TX = AW'(8'h04), A_CTRL = AW'(8'h08),
                            A_IE = AW'(8'h0C), A_STAT = AW'(8'h14);
  localparam logic [31:0] CTRL_MASK = 32'h0007_1FF7 | (32'((1 << CSW) - 1) << 24);
  localparam logic [31:0] IE_MASK   = 32'h0000_0009;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;
  st_t st;

  logic [31:0] ctrl_q, ie_q;
  wire en  = ctrl_q[0];
  wire mst = ctrl_q[1];
  wire xch = ctrl_q[2];
  wire pol = ctrl_q[4];
  wire pha = ctrl_q[5];
  wire ssc = ctrl_q[6];
  wire ssp = ctrl_q[7];
  wire [4:0]     wl   = ctrl_q[12:8];
  wire [2:0]     rate = ctrl_q[18:16];
  wire [CSW-1:0] csel = ctrl_q[24 +: CSW];

  logic [31:0]   tx_mem [DEPTH];
  logic [31:0]   rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  logic [9:0]  div_cnt;
  logic        sck, first, cs_act;
  logic [31:0] tx_sh, rx_sh;
  logic [5:0]  bit_cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire wr = bus_en && bus_we;
  wire rd = bus_en && !bus_we;
  wire tx_empty = (tx_cnt == '0);
  wire tx_full  = (tx_cnt == CW'(DEPTH));
  wire rx_ne    = (rx_cnt != '0);
  wire rx_full  = (rx_cnt == CW'(DEPTH));

  wire [9:0] half_m1 = (10'd2 << rate) - 10'd1;
  wire tick = (st != S_IDLE) && (div_cnt == half_m1);
  wire word_done = (st == S_SHIFT) && tick && sck && (bit_cnt == {1'b0, wl});
  wire start_ld = en && !tx_empty &&
                  ((st == S_IDLE && mst && xch) || (st == S_GAP && tick));
  wire xch_clr = en && ((st == S_IDLE && mst && xch && tx_empty) ||
                        (st == S_GAP && tick && !start_ld));
  wire [31:0] rx_word = pha ? {rx_sh[30:0], miso} : rx_sh;

  wire tx_push = wr && (bus_addr == A_TX) && !tx_full;
  wire rx_pop  = rd && (bus_addr == A_RX) && rx_ne;
  wire rx_push = word_done && !rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ie_q   <= '0;
    end else begin
      if (wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata & CTRL_MASK;
      else if (xch_clr)             ctrl_q[2] <= 1'b0;
      if (wr && bus_addr == A_IE)   ie_q <= bus_wdata & IE_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push)  tx_wp <= nxt(tx_wp);
      if (start_ld) tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(start_ld);
      if (rx_push)  rx_wp <= nxt(rx_wp);
      if (rx_pop)   rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; div_cnt <= '0; sck <= 1'b0; first <= 1'b0; cs_act <= 1'b0;
      tx_sh <= '0; rx_sh <= '0; bit_cnt <= '0;
    end else if (!en) begin
      st <= S_IDLE; div_cnt <= '0; sck <= 1'b0; cs_act <= 1'b0;
    end else if (start_ld) begin
      st <= S_SHIFT; div_cnt <= '0; sck <= 1'b0; first <= 1'b1; cs_act <= 1'b1;
      tx_sh <= tx_mem[tx_rp] << (5'd31 - wl);
      rx_sh <= '0; bit_cnt <= '0;
    end else if (st != S_IDLE) begin
      if (!tick) begin
        div_cnt <= div_cnt + 10'd1;
      end else begin
        div_cnt <= '0;
        if (st == S_GAP) begin
          st <= S_IDLE; cs_act <= 1'b0;
        end else begin
          sck <= ~sck;
          if (!sck) begin
            if (pha) begin
              if (!first) tx_sh <= tx_sh << 1;
              first <= 1'b0;
            end else begin
              rx_sh <= {rx_sh[30:0], miso};
            end
          end else begin
            if (pha) rx_sh <= {rx_sh[30:0], miso};
            else     tx_sh <= tx_sh << 1;
            bit_cnt <= bit_cnt + 6'd1;
            if (word_done) begin
              st <= S_GAP; cs_act <= !ssc;
            end
          end
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_RX:    bus_rdata = rx_ne ? rx_mem[rx_rp] : 32'h0;
      A_CTRL:  bus_rdata = ctrl_q;
      A_IE:    bus_rdata = ie_q;
      A_STAT:  bus_rdata = {28'h0, rx_ne, tx_full, 1'b0, tx_empty};
      default: bus_rdata = 32'h0;
    endcase
  end

  assign irq  = (ie_q[0] && tx_empty) || (ie_q[3] && rx_ne);
  assign sclk = sck ^ pol;
  assign mosi = (st != S_IDLE) && tx_sh[31];

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_o[i] = (cs_act && csel == CSW'(i)) ? ssp : ~ssp;
  end

  p_tx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));
  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_TX && tx_full && !start_ld) |=> tx_full);
  p_rx_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_pop) |=> rx_full);
  p_cs_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o ^ {NCS{~ssp}}));
  p_idle_sclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (sclk == pol));
  p_xch_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(xch) && !$past(wr && bus_addr == A_CTRL)) |-> tx_empty);
  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == A_RX && !rx_ne) |-> (bus_rdata == 32'h0));
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == 32'h0) |-> !irq);
endmodule

// File: tb/spi_fifo_master_bench.sv
module spi_fifo_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_RX = 5'h00, A_TX = 5'h04, A_CTRL = 5'h08, A_IE = 5'h0C, A_STAT = 5'h14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, sclk, mosi, miso;
  logic [3:0] cs_o;
  logic inv_q = 1'b0;

  assign miso = mosi ^ inv_q;
  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_fifo_master u_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_o(cs_o));

  int checks = 0, errors = 0;
  int cur_n = 8, cur_rate = 0, cur_sel = 0;
  logic cur_pol = 0, cur_pha = 0, cur_ssp = 0;
  logic [31:0] cur_ctrl = '0;
  logic [31:0] expq[$], rxq[$];
  int cs_rises = 0;
  longint cyc = 0;
  logic mon_en = 0, sclk_prev = 0, cs_prev = 0, have_lead = 0;
  logic [31:0] mon_word = '0;
  int mon_bits = 0;
  longint last_lead = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    logic csa, lead;
    logic [31:0] e;
    csa = (cs_o[cur_sel] == cur_ssp);
    if (rst_n && csa && !cs_prev) cs_rises++;
    cs_prev = csa;
    if (rst_n && mon_en && sclk != sclk_prev) begin
      lead = (sclk_prev == cur_pol);
      if (lead) begin
        chk(csa, "R8 select active at leading edge", {31'h0, csa}, 32'h1);
        if (have_lead)
          chk(cyc - last_lead == longint'(4 << cur_rate), "R3 sclk period",
              32'(cyc - last_lead), 32'(4 << cur_rate));
        have_lead = 1;
        last_lead = cyc;
      end
      if (lead != cur_pha) begin
        mon_word = {mon_word[30:0], mosi};
        mon_bits++;
        if (mon_bits == cur_n) begin
          e = (expq.size() != 0) ? expq.pop_front() : 32'hDEAD_BEEF;
          chk((mon_word & mask_of(cur_n)) == e, "R2 R4 serial word",
              mon_word & mask_of(cur_n), e);
          mon_bits = 0; mon_word = '0; have_lead = 0;
        end
      end
    end
    sclk_prev = sclk;
  end

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_en = 0;
  endtask

  task automatic cfg(input int n, input logic pol, input logic pha, input int rate,
                     input int sel, input logic ssp, input logic ssc, input logic inv);
    logic [31:0] r;
    cur_n = n; cur_pol = pol; cur_pha = pha; cur_rate = rate; cur_sel = sel; cur_ssp = ssp;
    inv_q = inv;
    cur_ctrl = 32'h3 | (32'(pol) << 4) | (32'(pha) << 5) | (32'(ssc) << 6) | (32'(ssp) << 7) |
               (32'(n - 1) << 8) | (32'(rate) << 16) | (32'(sel) << 24);
    bus_wr(A_CTRL, cur_ctrl);
    bus_rd(A_CTRL, r);
    chk(r == cur_ctrl, "R1 control readback", r, cur_ctrl);
  endtask

  task automatic push(input logic [31:0] w, input bit tx_ok, input bit rx_ok);
    bus_wr(A_TX, w);
    if (tx_ok) expq.push_back(w & mask_of(cur_n));
    if (rx_ok) rxq.push_back((w ^ {32{inv_q}}) & mask_of(cur_n));
  endtask

  task automatic go(input int exp_rises);
    logic [31:0] r;
    mon_bits = 0; mon_word = '0; have_lead = 0;
    cs_rises = 0;
    mon_en = 1;
    bus_wr(A_CTRL, cur_ctrl | 32'h4);
    do bus_rd(A_CTRL, r); while (r[2]);
    repeat (4) @(negedge clk);
    mon_en = 0;
    chk(expq.size() == 0, "R2 every queued word sent", 32'(expq.size()), 32'h0);
    chk(cs_rises == exp_rises, "R8 select activations", 32'(cs_rises), 32'(exp_rises));
    bus_rd(A_STAT, r);
    chk(r[0] == 1'b1, "R7 start cleared after drain", {31'h0, r[0]}, 32'h1);
  endtask

  task automatic drain();
    logic [31:0] r, e;
    while (rxq.size() != 0) begin
      e = rxq.pop_front();
      bus_rd(A_RX, r);
      chk(r == e, "R5 received word", r, e);
    end
    bus_rd(A_STAT, r);
    chk(r[3] == 1'b0, "R5 ready bit clear after drain", {31'h0, r[3]}, 32'h0);
    bus_rd(A_RX, r);
    chk(r == 32'h0, "R5 R10 empty read is zero", r, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_o == 4'hF, "R1 reset selects", {28'h0, cs_o}, 32'hF);
    chk(!sclk && !mosi && !irq, "R1 reset outputs", {29'h0, sclk, mosi, irq}, 32'h0);
    bus_rd(A_CTRL, r); chk(r == 32'h0, "R1 reset control", r, 32'h0);
    bus_rd(A_STAT, r); chk(r == 32'h1, "R1 reset status", r, 32'h1);

    bus_wr(A_IE, 32'hFFFF_FFFF);
    bus_rd(A_IE, r); chk(r == 32'h9, "R1 enable readback", r, 32'h9);
    bus_wr(A_IE, 32'h1);
    @(negedge clk); chk(irq == 1'b1, "R9 tx empty raises irq", {31'h0, irq}, 32'h1);
    cur_n = 8;
    push(32'h0000_00A5, 1, 1);
    @(negedge clk); chk(irq == 1'b0, "R9 irq low with tx queued", {31'h0, irq}, 32'h0);

    cfg(8, 0, 0, 0, 0, 0, 0, 0);
    push(32'h0000_003C, 1, 1);
    go(1);
    chk(irq == 1'b1, "R9 irq after burst", {31'h0, irq}, 32'h1);
    bus_wr(A_IE, 32'h8);
    @(negedge clk); chk(irq == 1'b1, "R9 rx ready raises irq", {31'h0, irq}, 32'h1);
    drain();
    @(negedge clk); chk(irq == 1'b0, "R9 irq low after drain", {31'h0, irq}, 32'h0);
    bus_wr(A_IE, 32'h0);

    cfg(16, 1, 1, 2, 2, 1, 1, 1);
    for (int i = 0; i < 3; i++) push(32'h1234_8001 + 32'(i) * 32'h0F0F_3333, 1, 1);
    go(3);
    chk(cs_o == 4'h0, "R8 idle level with high-active select", {28'h0, cs_o}, 32'h0);
    drain();

    cfg(32, 0, 1, 1, 1, 0, 0, 0);
    push(32'h8000_0001, 1, 1);
    push(32'h5A3C_E71F, 1, 1);
    go(1);
    drain();

    cfg(5, 1, 0, 7, 3, 0, 1, 1);
    push(32'hFFFF_FF11, 1, 1);
    push(32'h0000_000A, 1, 1);
    go(2);
    drain();

    cfg(1, 0, 0, 0, 0, 0, 0, 1);
    push(32'h1, 1, 1);
    push(32'h0, 1, 1);
    go(1);
    drain();

    cfg(8, 0, 0, 0, 0, 0, 0, 0);
    cs_rises = 0;
    bus_wr(A_CTRL, cur_ctrl | 32'h4);
    repeat (3) @(negedge clk);
    bus_rd(A_CTRL, r);
    chk(r[2] == 1'b0, "R7 start with empty fifo clears", {31'h0, r[2]}, 32'h0);
    chk(cs_rises == 0, "R7 no select on empty start", 32'(cs_rises), 32'h0);

    cfg(4, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 9; i++) push(32'(i + 3), i < 8, i < 8);
    bus_rd(A_STAT, r);
    chk(r[2] == 1'b1, "R6 full flag", {31'h0, r[2]}, 32'h1);
    go(1);
    push(32'hE, 1, 0);
    go(1);
    bus_rd(A_STAT, r);
    chk(r[3] == 1'b1, "R10 rx still holds words", {31'h0, r[3]}, 32'h1);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule